// File: doc/BRIEF.md
# Round-Robin Request Arbiter with Per-Port Queues

This block collects memory requests from several requestor ports, each with its own small FIFO queue, and hands them one at a time to a single downstream request manager. A queued entry holds the originating port number, an address, a write flag and a burst length. Only the entry at the head of each queue competes for the grant.

The winning entry is offered downstream with a valid/ready handshake. The handshake removes the entry from its queue. The arbiter then waits for a completion pulse before it scans the queues again, so only one transaction is in flight at any time. Grants rotate round-robin across the non-empty queues. Starting from reset, port 0 is the most favoured. Whenever every queue drains, priority returns to port 0.

Top module: `rr_req_arbiter`

## Requirements
- R1: A port entry is written into that port's queue on a clock edge where `port_valid_i` is high and `port_full_o` is low. `port_full_o` is high while the queue holds `Q_DEPTH` entries. A push attempted while full is dropped and never granted.
- R2: The entries of one port are offered in the order they were pushed. The fields are unchanged, and `req_port_o` equals the port index.
- R3: Starting from reset, when several queues are non-empty, the lowest-numbered non-empty port is granted first.
- R4: After a grant to port k, the next grant goes to the first non-empty port found searching upward from k+1, wrapping modulo `N_PORTS`.
- R5: When all queues are empty and no offer is pending, the search start returns to port 0.
- R6: While `req_valid_o` is high, `grant_o` is one-hot with the bit at `req_port_o` set. Otherwise `grant_o` is zero.
- R7: An offer holds its valid signal, grant and fields stable until `req_ready_i` is sampled high. That edge pops the entry.
- R8: After the handshake, `busy_o` is high and no new offer appears until `done_i` is sampled high. `done_i` has no effect while `busy_o` is low.
- R9: After reset, `req_valid_o`, `grant_o`, `busy_o` and all `port_full_o` bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_valid_i | input | N_PORTS | Per-port push request |
| port_wr_i | input | N_PORTS | Per-port write flag (1 = write, 0 = read) |
| port_addr_i | input | N_PORTS x ARB_ADDR_W | Per-port address |
| port_burst_i | input | N_PORTS x ARB_BURST_W | Per-port burst length |
| port_full_o | output | N_PORTS | Per-port queue full |
| req_valid_o | output | 1 | Offer to the request manager valid |
| req_ready_i | input | 1 | Request manager accepts the offer |
| req_port_o | output | ARB_PID_W | Port of the offered entry |
| req_addr_o | output | ARB_ADDR_W | Address of the offered entry |
| req_wr_o | output | 1 | Write flag of the offered entry |
| req_burst_o | output | ARB_BURST_W | Burst length of the offered entry |
| grant_o | output | N_PORTS | One-hot grant during an offer |
| busy_o | output | 1 | Transaction in flight, waiting for completion |
| done_i | input | 1 | Completion pulse from downstream |

## Verification
The bench sweeps every non-empty combination of loaded ports, with two entries per port. The rotation order is predicted from an arithmetic pointer model. A pointer that failed to wrap, or skipped k+1, would grant the wrong port in the multi-port patterns. A design without the return to port 0 is caught by a load of ports 1 and 2 followed by ports 0 and 3: it would grant port 3 before port 0.

Overfilling one queue checks that exactly `Q_DEPTH` entries come out. A queue that accepted the extra push, or lost one, would produce a different count. A completion pulse sent during an offer checks that `done_i` is ignored outside a transaction. The bench also holds `req_ready_i` low across cycles, which exposes an offer that changes before it is taken.

// File: rtl/rr_arb_pkg.sv
package rr_arb_pkg;
  parameter int unsigned ARB_ADDR_W  = 32;
  parameter int unsigned ARB_BURST_W = 8;
  parameter int unsigned ARB_PID_W   = 4;

  typedef struct packed {
    logic [ARB_PID_W-1:0]   pid;
    logic [ARB_ADDR_W-1:0]  addr;
    logic                   wr;
    logic [ARB_BURST_W-1:0] burst;
  } arb_req_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OFFER = 2'd1,
    ST_WAIT  = 2'd2
  } arb_state_e;
endpackage

// File: rtl/req_fifo.sv
module req_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int unsigned N  = 4,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] start_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    logic found;
    found = 1'b0;
    idx_o = '0;
    for (int off = 0; off < int'(N); off++) begin
      int j;
      j = (int'(start_i) + off) % int'(N);
      if (!found && req_i[j]) begin
        found = 1'b1;
        idx_o = IW'(j);
      end
    end
    any_o = found;
    gnt_o = found ? (N'(1) << idx_o) : '0;
  end
endmodule

// File: rtl/rr_req_arbiter.sv
module rr_req_arbiter
  import rr_arb_pkg::*;
#(
  parameter int unsigned N_PORTS = 4,
  parameter int unsigned Q_DEPTH = 4
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic [N_PORTS-1:0]                     port_valid_i,
  input  logic [N_PORTS-1:0]                     port_wr_i,
  input  logic [N_PORTS-1:0][ARB_ADDR_W-1:0]     port_addr_i,
  input  logic [N_PORTS-1:0][ARB_BURST_W-1:0]    port_burst_i,
  output logic [N_PORTS-1:0]                     port_full_o,
  output logic                                   req_valid_o,
  input  logic                                   req_ready_i,
  output logic [ARB_PID_W-1:0]                   req_port_o,
  output logic [ARB_ADDR_W-1:0]                  req_addr_o,
  output logic                                   req_wr_o,
  output logic [ARB_BURST_W-1:0]                 req_burst_o,
  output logic [N_PORTS-1:0]                     grant_o,
  output logic                                   busy_o,
  input  logic                                   done_i
);
  localparam int unsigned IW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;
  localparam int unsigned EW = $bits(arb_req_t);

  arb_state_e          state_q;
  logic [N_PORTS-1:0]  gnt_q;
  logic [IW-1:0]       idx_q, ptr_q;
  logic [N_PORTS-1:0]  nonempty, pop;
  arb_req_t            head [N_PORTS];
  logic [N_PORTS-1:0]  pick_gnt;
  logic [IW-1:0]       pick_idx;
  logic                pick_any;
  logic                hs;
  arb_req_t            sel;

  assign hs = (state_q == ST_OFFER) && req_ready_i;

  for (genvar g = 0; g < N_PORTS; g++) begin : g_port
    arb_req_t    ent;
    logic [EW-1:0] hd;
    logic        emp;
    assign ent.pid   = ARB_PID_W'(g);
    assign ent.addr  = port_addr_i[g];
    assign ent.wr    = port_wr_i[g];
    assign ent.burst = port_burst_i[g];
    assign pop[g]    = hs && gnt_q[g];
    req_fifo #(.DEPTH(Q_DEPTH), .W(EW)) u_q (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (port_valid_i[g]),
      .data_i  (ent),
      .pop_i   (pop[g]),
      .data_o  (hd),
      .empty_o (emp),
      .full_o  (port_full_o[g])
    );
    assign head[g]     = arb_req_t'(hd);
    assign nonempty[g] = !emp;
  end

  rr_pick #(.N(N_PORTS)) u_pick (
    .req_i   (nonempty),
    .start_i (ptr_q),
    .gnt_o   (pick_gnt),
    .idx_o   (pick_idx),
    .any_o   (pick_any)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      gnt_q   <= '0;
      idx_q   <= '0;
      ptr_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (pick_any) begin
          state_q <= ST_OFFER;
          gnt_q   <= pick_gnt;
          idx_q   <= pick_idx;
        end
        ST_OFFER: if (req_ready_i) state_q <= ST_WAIT;
        ST_WAIT:  if (done_i) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
      // advance past the winner on handshake; snap to port 0 when all drained
      if (hs)
        ptr_q <= (idx_q == IW'(N_PORTS - 1)) ? '0 : idx_q + 1'b1;
      else if (!(|nonempty) && state_q != ST_OFFER)
        ptr_q <= '0;
    end
  end

  assign sel         = head[idx_q];
  assign req_valid_o = (state_q == ST_OFFER);
  assign grant_o     = req_valid_o ? gnt_q : '0;
  assign req_port_o  = sel.pid;
  assign req_addr_o  = sel.addr;
  assign req_wr_o    = sel.wr;
  assign req_burst_o = sel.burst;
  assign busy_o      = (state_q == ST_WAIT);
endmodule

// File: rtl/rr_req_arbiter_chk.sv
module rr_req_arbiter_chk
  import rr_arb_pkg::*;
#(
  parameter int unsigned N_PORTS = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   req_valid_o,
  input logic                   req_ready_i,
  input logic [ARB_PID_W-1:0]   req_port_o,
  input logic [ARB_ADDR_W-1:0]  req_addr_o,
  input logic [N_PORTS-1:0]     grant_o,
  input logic                   busy_o,
  input logic                   done_i
);
  a_r6_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> ($countones(grant_o) == 1 && grant_o[req_port_o]));
  a_r6_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_o |-> (grant_o == '0));
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=>
      (req_valid_o && $stable(grant_o) && $stable(req_addr_o)));
  a_r8_busy_after_hs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_ready_i) |=> busy_o);
  a_r8_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_i) |=> busy_o);
  a_r8_no_offer_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !req_valid_o);
endmodule

bind rr_req_arbiter rr_req_arbiter_chk #(.N_PORTS(N_PORTS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_o (req_valid_o),
  .req_ready_i (req_ready_i),
  .req_port_o  (req_port_o),
  .req_addr_o  (req_addr_o),
  .grant_o     (grant_o),
  .busy_o      (busy_o),
  .done_i      (done_i)
);

// File: tb/rr_req_arbiter_bench.sv
`timescale 1ns/1ps
module rr_req_arbiter_bench;
  import rr_arb_pkg::*;
  localparam int NP = 4;
  localparam int QD = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NP-1:0] p_valid = '0, p_wr = '0, p_full;
  logic [NP-1:0][ARB_ADDR_W-1:0]  p_addr = '0;
  logic [NP-1:0][ARB_BURST_W-1:0] p_burst = '0;
  logic req_valid, req_ready = 1'b0, req_wr, busy, done = 1'b0;
  logic [ARB_PID_W-1:0]   req_port;
  logic [ARB_ADDR_W-1:0]  req_addr;
  logic [ARB_BURST_W-1:0] req_burst;
  logic [NP-1:0] grant;

  int total = 0, bad = 0;
  int seq [NP];
  int mq [NP][QD];
  int mcnt [NP];
  int mptr = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rr_req_arbiter #(.N_PORTS(NP), .Q_DEPTH(QD)) u_rr_req_arbiter (
    .clk_i(clk), .rst_ni(rst_n),
    .port_valid_i(p_valid), .port_wr_i(p_wr), .port_addr_i(p_addr),
    .port_burst_i(p_burst), .port_full_o(p_full),
    .req_valid_o(req_valid), .req_ready_i(req_ready), .req_port_o(req_port),
    .req_addr_o(req_addr), .req_wr_o(req_wr), .req_burst_o(req_burst),
    .grant_o(grant), .busy_o(busy), .done_i(done)
  );

  function automatic logic [ARB_ADDR_W-1:0] f_addr(int p, int s);
    return ARB_ADDR_W'(p * 4096 + s);
  endfunction
  function automatic logic f_wr(int p, int s);
    return 1'((p + s) & 1);
  endfunction
  function automatic logic [ARB_BURST_W-1:0] f_burst(int p, int s);
    return ARB_BURST_W'((3 * s + p) & 255);
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic push_mask(logic [NP-1:0] m);
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      p_valid[p] = m[p];
      p_addr[p]  = f_addr(p, seq[p]);
      p_wr[p]    = f_wr(p, seq[p]);
      p_burst[p] = f_burst(p, seq[p]);
      if (m[p]) begin
        if (mcnt[p] < QD) begin
          mq[p][mcnt[p]] = seq[p];
          mcnt[p]++;
        end
        seq[p]++;
      end
    end
    @(negedge clk);
    p_valid = '0;
  endtask

  function automatic int all_cnt();
    int s = 0;
    for (int p = 0; p < NP; p++) s += mcnt[p];
    return s;
  endfunction

  task automatic wait_offer();
    for (int i = 0; i < 40 && !req_valid; i++) @(negedge clk);
  endtask

  task automatic serve_one();
    int w, s;
    wait_offer();
    w = -1;
    for (int off = 0; off < NP; off++) begin
      int j;
      j = (mptr + off) % NP;
      if (w < 0 && mcnt[j] > 0) w = j;
    end
    s = mq[w][0];
    chk(req_valid == 1'b1, "R3 offer present", req_valid, 1);
    chk(int'(req_port) == w, "R4 rotation port", req_port, w);
    chk(grant == NP'(1 << w), "R6 grant onehot", grant, 1 << w);
    chk(req_addr == f_addr(w, s) && req_wr == f_wr(w, s) && req_burst == f_burst(w, s),
        "R2 fields", req_addr, f_addr(w, s));
    @(negedge clk);
    chk(req_valid && int'(req_port) == w && req_addr == f_addr(w, s),
        "R7 held", req_addr, f_addr(w, s));
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    chk(busy == 1'b1 && req_valid == 1'b0, "R8 busy after handshake", busy, 1);
    @(negedge clk);
    @(negedge clk);
    chk(req_valid == 1'b0 && grant == '0, "R8 no offer while busy", req_valid, 0);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    for (int k = 0; k < QD - 1; k++) mq[w][k] = mq[w][k+1];
    mcnt[w]--;
    mptr = (w + 1) % NP;
    if (all_cnt() == 0) mptr = 0;
  endtask

  task automatic drain();
    while (all_cnt() > 0) serve_one();
    repeat (3) @(negedge clk);
    chk(req_valid == 1'b0 && busy == 1'b0, "R1 nothing left", req_valid, 0);
  endtask

  initial begin
    for (int p = 0; p < NP; p++) begin seq[p] = 0; mcnt[p] = 0; end
    #20;
    chk(req_valid == 0 && grant == '0 && busy == 0 && p_full == '0, "R9 reset", req_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_valid == 0 && busy == 0, "R9 idle after reset", req_valid, 0);

    // all four loaded twice: 0,1,2,3,0,1,2,3
    push_mask(4'b1111);
    push_mask(4'b1111);
    drain();

    // snap back: serve 1,2, then 0 must beat 3
    push_mask(4'b0110);
    drain();
    push_mask(4'b1001);
    wait_offer();
    chk(int'(req_port) == 0, "R5 snap to port 0", req_port, 0);
    drain();

    // overfill port 2 with no acceptance
    for (int i = 0; i < QD + 1; i++) push_mask(4'b0100);
    chk(p_full[2] == 1'b1, "R1 full flag", p_full[2], 1);
    chk(p_full[1] == 1'b0, "R1 other port not full", p_full[1], 0);
    drain();
    chk(p_full[2] == 1'b0, "R1 full cleared", p_full[2], 0);

    // done while not busy is ignored
    push_mask(4'b0010);
    wait_offer();
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    @(negedge clk);
    chk(req_valid == 1'b1 && busy == 1'b0, "R8 stray done ignored", req_valid, 1);
    drain();

    // sweep every pattern with two entries per port
    for (int m = 1; m < (1 << NP); m++) begin
      push_mask(NP'(m));
      push_mask(NP'(m));
      drain();
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule